// File: doc/BRIEF.md
# Debug Status Register Access Gate

This block sits beside the debug status and control register of a processor core. It judges each coprocessor read or write aimed at that register. For every valid request it names exactly one of five outcomes: the access completes, the instruction is undefined, the access traps to level 2, it takes a hypervisor trap, or it traps to level 3. It also gives the syndrome class that the exception logic records. The core's exception machinery takes the exception; this block only makes the decision.

The decision uses three kinds of input. The first is the current exception level. The second is whether level 2 is enabled and whether it runs 64-bit or 32-bit, and whether level 3 exists and which width it runs. The third is the debug trap bits from the hypervisor and monitor configuration. The fixed priority among these checks follows the exception level. The outcome is combinational from the valid-qualified request. A permitted write also gives a single-cycle write strobe toward the register one clock later.

Top module: `dbg_ctl_access_gate`

## Requirements
- R1: A request whose fields are not coprocessor 4'b1110, opc1 3'b000, CRn 4'b0000, CRm 4'b0010, opc2 3'b010 deasserts every outcome bit, gives syndrome 0 and raises no write strobe. Reads and writes use this same encoding.
- R2: A matching request at level 0 (cur_el = 2'd0) gives the undefined outcome, whatever the trap bits are.
- R3: At level 1 (cur_el = 2'd1), when level 2 is enabled and runs 64-bit, and either hyp64_tde or hyp64_tda is set, the outcome is trap-to-level-2. This check comes first.
- R4: At level 1, when R3 does not apply and level 2 is enabled and runs 32-bit, and either hyp32_tde or hyp32_tda is set, the outcome is hypervisor trap.
- R5: At level 1 after the level-2 checks, and at level 2 (cur_el = 2'd2), when level 3 is present and runs 64-bit and mon64_tda is set, the outcome is trap-to-level-3. Otherwise the outcome is permit.
- R6: A matching request at level 3 (cur_el = 2'd3) is always permitted.
- R7: Each trap outcome (trap-to-level-2, hypervisor trap, trap-to-level-3) drives syn_class = 6'h05. Permit, undefined and no outcome drive syn_class = 0.
- R8: The outcome bits are one-hot for a valid matching request and all zero when req_valid is low. Bit order is [0] permit, [1] undefined, [2] trap-to-level-2, [3] hypervisor trap, [4] trap-to-level-3.
- R9: reg_wr_en is high for exactly the one cycle after a clock edge that sampled a valid, permitted write. Reads, trapped writes and undefined writes never raise it.
- R10: While rst_n is low at a clock edge, reg_wr_en is low after that edge.
- R11: At level 2, the level-2 trap bits (hyp64_*, hyp32_*) have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor number field |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level |
| el2_enabled | input | 1 | Level 2 enabled in current state |
| el2_is_32 | input | 1 | Level 2 runs 32-bit |
| el3_present | input | 1 | Level 3 implemented |
| el3_is_32 | input | 1 | Level 3 runs 32-bit |
| hyp64_tde | input | 1 | 64-bit level-2 debug exception routing bit |
| hyp64_tda | input | 1 | 64-bit level-2 debug access trap bit |
| hyp32_tde | input | 1 | 32-bit hypervisor debug exception routing bit |
| hyp32_tda | input | 1 | 32-bit hypervisor debug access trap bit |
| mon64_tda | input | 1 | 64-bit level-3 debug access trap bit |
| res_permit | output | 1 | Access completes |
| res_undef | output | 1 | Instruction undefined |
| res_trap_el2 | output | 1 | Trap to level 2 |
| res_hyp_trap | output | 1 | Hypervisor trap (32-bit level 2) |
| res_trap_el3 | output | 1 | Trap to level 3 |
| syn_class | output | 6 | Syndrome class for trap outcomes |
| reg_wr_en | output | 1 | One-cycle write strobe for a permitted write |

## Verification
The hardest cases to reach are the ones where a lower-priority trap condition is also armed but must lose. Examples: a level-1 access with both a 64-bit level-2 trap bit and the monitor trap bit set, or a 32-bit level 2 whose unused 64-bit trap bits are set. The stimulus therefore sets these conflicting configurations on purpose, so that each priority step has to override another armed step. It also places back-to-back permitted writes and a write followed by idle next to each other, so the write strobe's exact one-cycle width is observed.

// File: rtl/dbg_gate_pkg.sv
// Package: shared outcome encoding and register-selector constants for the
// debug status register access gate. Assumes a 2-bit exception level.
package dbg_gate_pkg;

    localparam int EL_W       = 2;
    localparam int N_OUTCOMES = 5;
    localparam int SYN_W      = 6;

    typedef enum logic [2:0] {
        OC_PERMIT   = 3'd0,
        OC_UNDEF    = 3'd1,
        OC_TRAP_EL2 = 3'd2,
        OC_HYP_TRAP = 3'd3,
        OC_TRAP_EL3 = 3'd4,
        OC_NONE     = 3'd7
    } outcome_e;

    localparam logic [EL_W-1:0] LVL_0 = 2'd0;
    localparam logic [EL_W-1:0] LVL_1 = 2'd1;
    localparam logic [EL_W-1:0] LVL_2 = 2'd2;
    localparam logic [EL_W-1:0] LVL_3 = 2'd3;

    typedef struct packed {
        logic el2_enabled;
        logic el2_is_32;
        logic el3_present;
        logic el3_is_32;
        logic hyp64_tde;
        logic hyp64_tda;
        logic hyp32_tde;
        logic hyp32_tda;
        logic mon64_tda;
    } trap_cfg_t;

endpackage

// File: rtl/dbg_enc_match.sv
// Module: instruction field decoder. Compares the five coprocessor fields
// with the selector of the debug status register. Purely combinational;
// assumes the fields are stable whenever the request is valid.
module dbg_enc_match #(
    parameter logic [3:0] SEL_CP   = 4'b1110,
    parameter logic [2:0] SEL_OPC1 = 3'b000,
    parameter logic [3:0] SEL_CRN  = 4'b0000,
    parameter logic [3:0] SEL_CRM  = 4'b0010,
    parameter logic [2:0] SEL_OPC2 = 3'b010
) (
    input  logic [3:0] cp,
    input  logic [2:0] opc1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] opc2,
    output logic       hit
);
    logic [4:0] field_eq;

    // Compare each field with its selector value.
    always_comb begin
        field_eq[0] = (cp   == SEL_CP);
        field_eq[1] = (opc1 == SEL_OPC1);
        field_eq[2] = (crn  == SEL_CRN);
        field_eq[3] = (crm  == SEL_CRM);
        field_eq[4] = (opc2 == SEL_OPC2);
    end

    // The register is selected only when every field agrees.
    assign hit = &field_eq;

endmodule

// File: rtl/dbg_trap_prio.sv
// Module: priority chain that picks one outcome from the exception level
// and the trap configuration. Purely combinational; assumes the
// configuration inputs are already qualified for the current state.
module dbg_trap_prio
    import dbg_gate_pkg::*;
(
    input  logic [EL_W-1:0] cur_el,
    input  trap_cfg_t       cfg,
    output outcome_e        outcome
);
    logic l2_trap64;
    logic l2_trap32;
    logic l3_trap64;

    // Conditions for each trap step, each qualified by the width of its level.
    always_comb begin
        l2_trap64 = cfg.el2_enabled && !cfg.el2_is_32 && (cfg.hyp64_tde || cfg.hyp64_tda);
        l2_trap32 = cfg.el2_enabled &&  cfg.el2_is_32 && (cfg.hyp32_tde || cfg.hyp32_tda);
        l3_trap64 = cfg.el3_present && !cfg.el3_is_32 && cfg.mon64_tda;
    end

    // Pick the outcome in fixed order for each exception level.
    always_comb begin
        unique case (cur_el)
            LVL_0: outcome = OC_UNDEF;
            LVL_1: begin
                if (l2_trap64)      outcome = OC_TRAP_EL2;
                else if (l2_trap32) outcome = OC_HYP_TRAP;
                else if (l3_trap64) outcome = OC_TRAP_EL3;
                else                outcome = OC_PERMIT;
            end
            LVL_2: outcome = l3_trap64 ? OC_TRAP_EL3 : OC_PERMIT;
            default: outcome = OC_PERMIT;
        endcase
    end

endmodule

// File: rtl/dbg_outcome_drv.sv
// Module: expands the selected outcome into one-hot result lines and the
// syndrome class. Assumes 'active' is already the valid-and-hit qualifier.
module dbg_outcome_drv
    import dbg_gate_pkg::*;
#(
    parameter logic [SYN_W-1:0] TRAP_SYN = 6'h05
) (
    input  logic                  active,
    input  outcome_e              outcome,
    output logic [N_OUTCOMES-1:0] onehot,
    output logic [SYN_W-1:0]      syn_class
);
    logic any_trap;

    // One result line per outcome code.
    generate
        for (genvar i = 0; i < N_OUTCOMES; i++) begin : g_line
            assign onehot[i] = active && (outcome == outcome_e'(i));
        end
    endgenerate

    // Every trap target reports the same syndrome class.
    always_comb begin
        any_trap  = onehot[OC_TRAP_EL2] || onehot[OC_HYP_TRAP] || onehot[OC_TRAP_EL3];
        syn_class = any_trap ? TRAP_SYN : '0;
    end

endmodule

// File: rtl/dbg_wr_pulse.sv
// Module: registers the write strobe for a permitted write so that the
// register is written in the cycle after the request. Synchronous
// active-low reset.
module dbg_wr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    output logic wr_en
);
    // Capture a permitted write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_en <= 1'b0;
        else        wr_en <= wr_ok;
    end

endmodule

// File: rtl/dbg_ctl_access_gate.sv
// Module: top of the access gate for the debug status register. Decodes
// the instruction fields, runs the trap priority chain and drives one-hot
// results, the syndrome class and a delayed write strobe. Outcomes are
// combinational from the request; only the write strobe is registered.
module dbg_ctl_access_gate
    import dbg_gate_pkg::*;
#(
    parameter logic [3:0]       SEL_CP   = 4'b1110,
    parameter logic [2:0]       SEL_OPC1 = 3'b000,
    parameter logic [3:0]       SEL_CRN  = 4'b0000,
    parameter logic [3:0]       SEL_CRM  = 4'b0010,
    parameter logic [2:0]       SEL_OPC2 = 3'b010,
    parameter logic [SYN_W-1:0] TRAP_SYN = 6'h05
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [3:0]       req_cp,
    input  logic [2:0]       req_opc1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_opc2,
    input  logic [EL_W-1:0]  cur_el,
    input  logic             el2_enabled,
    input  logic             el2_is_32,
    input  logic             el3_present,
    input  logic             el3_is_32,
    input  logic             hyp64_tde,
    input  logic             hyp64_tda,
    input  logic             hyp32_tde,
    input  logic             hyp32_tda,
    input  logic             mon64_tda,
    output logic             res_permit,
    output logic             res_undef,
    output logic             res_trap_el2,
    output logic             res_hyp_trap,
    output logic             res_trap_el3,
    output logic [SYN_W-1:0] syn_class,
    output logic             reg_wr_en
);
    logic                  sel_hit;
    logic                  active;
    trap_cfg_t             cfg;
    outcome_e              outcome;
    logic [N_OUTCOMES-1:0] lines;

    dbg_enc_match #(
        .SEL_CP(SEL_CP), .SEL_OPC1(SEL_OPC1), .SEL_CRN(SEL_CRN),
        .SEL_CRM(SEL_CRM), .SEL_OPC2(SEL_OPC2)
    ) u_match (
        .cp(req_cp), .opc1(req_opc1), .crn(req_crn),
        .crm(req_crm), .opc2(req_opc2), .hit(sel_hit)
    );

    // Gather the trap configuration into one bundle.
    always_comb begin
        cfg.el2_enabled = el2_enabled;
        cfg.el2_is_32   = el2_is_32;
        cfg.el3_present = el3_present;
        cfg.el3_is_32   = el3_is_32;
        cfg.hyp64_tde   = hyp64_tde;
        cfg.hyp64_tda   = hyp64_tda;
        cfg.hyp32_tde   = hyp32_tde;
        cfg.hyp32_tda   = hyp32_tda;
        cfg.mon64_tda   = mon64_tda;
    end

    dbg_trap_prio u_prio (
        .cur_el(cur_el), .cfg(cfg), .outcome(outcome)
    );

    assign active = req_valid && sel_hit;

    dbg_outcome_drv #(.TRAP_SYN(TRAP_SYN)) u_drv (
        .active(active), .outcome(outcome), .onehot(lines), .syn_class(syn_class)
    );

    // Map the outcome lines onto the named result ports.
    always_comb begin
        res_permit   = lines[OC_PERMIT];
        res_undef    = lines[OC_UNDEF];
        res_trap_el2 = lines[OC_TRAP_EL2];
        res_hyp_trap = lines[OC_HYP_TRAP];
        res_trap_el3 = lines[OC_TRAP_EL3];
    end

    dbg_wr_pulse u_pulse (
        .clk(clk), .rst_n(rst_n),
        .wr_ok(res_permit && req_write), .wr_en(reg_wr_en)
    );

endmodule

// File: rtl/dbg_ctl_access_gate_chk.sv
// Module: assertion checker bound to the access gate. Observes ports only.
module dbg_ctl_access_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_write,
    input logic [3:0] req_cp,
    input logic [2:0] req_opc1,
    input logic [3:0] req_crn,
    input logic [3:0] req_crm,
    input logic [2:0] req_opc2,
    input logic [1:0] cur_el,
    input logic       el3_present,
    input logic       el3_is_32,
    input logic       mon64_tda,
    input logic       res_permit,
    input logic       res_undef,
    input logic       res_trap_el2,
    input logic       res_hyp_trap,
    input logic       res_trap_el3,
    input logic [5:0] syn_class,
    input logic       reg_wr_en
);
    logic [4:0] res_v;
    logic       enc_ok;
    assign res_v  = {res_trap_el3, res_hyp_trap, res_trap_el2, res_undef, res_permit};
    assign enc_ok = (req_cp == 4'b1110) && (req_opc1 == 3'b000) && (req_crn == 4'b0000)
                 && (req_crm == 4'b0010) && (req_opc2 == 3'b010);

    assert_nomatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_ok |-> (res_v == 5'd0 && syn_class == 6'd0));
    assert_el0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_ok && cur_el == 2'd0) |-> res_undef);
    assert_el2_mon_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_ok && cur_el == 2'd2 && el3_present && !el3_is_32 && mon64_tda)
        |-> res_trap_el3);
    assert_el3_permit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_ok && cur_el == 2'd3) |-> res_permit);
    assert_trap_syn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_trap_el2 || res_hyp_trap || res_trap_el3) |-> (syn_class == 6'h05));
    assert_nontrap_syn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_trap_el2 || res_hyp_trap || res_trap_el3) |-> (syn_class == 6'h00));
    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_ok) |-> ($countones(res_v) == 1));
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (res_v == 5'd0));
    assert_wr_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && res_permit) |=> reg_wr_en);
    assert_wr_only_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_write && res_permit) |=> !reg_wr_en);
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> !reg_wr_en);
endmodule

bind dbg_ctl_access_gate dbg_ctl_access_gate_chk u_chk (.*);

// File: tb/tb_dbg_ctl_access_gate.sv
`timescale 1ns/1ps
module tb_dbg_ctl_access_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [3:0] req_cp = 4'b1110;
    logic [2:0] req_opc1 = 3'b000;
    logic [3:0] req_crn = 4'b0000;
    logic [3:0] req_crm = 4'b0010;
    logic [2:0] req_opc2 = 3'b010;
    logic [1:0] cur_el = 2'd0;
    logic el2_enabled = 0, el2_is_32 = 0, el3_present = 0, el3_is_32 = 0;
    logic hyp64_tde = 0, hyp64_tda = 0, hyp32_tde = 0, hyp32_tda = 0, mon64_tda = 0;
    logic res_permit, res_undef, res_trap_el2, res_hyp_trap, res_trap_el3, reg_wr_en;
    logic [5:0] syn_class;

    int n_checks = 0;
    int n_fail   = 0;
    bit stim_done = 0;

    typedef struct {
        logic [4:0] oc;
        logic [5:0] syn;
        logic       wr;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // Outcome bit order: [0] permit [1] undef [2] trap-el2 [3] hyp [4] trap-el3
    localparam logic [4:0] E_NONE = 5'b00000, E_PERM = 5'b00001, E_UNDEF = 5'b00010,
                           E_EL2 = 5'b00100, E_HYP = 5'b01000, E_EL3 = 5'b10000;

    always #10 clk = ~clk;

    dbg_ctl_access_gate dut (.*);

    // Driver: apply one request at the falling edge and queue its expectation.
    // cfg order: {el2_en, el2_32, el3_p, el3_32, h64tde, h64tda, h32tde, h32tda, m64tda}
    task automatic drive(input logic v, input logic w, input logic [3:0] cp,
                         input logic [3:0] crm, input logic [1:0] el,
                         input logic [8:0] cfg, input logic [4:0] oc,
                         input logic ewr, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_write = w; req_cp = cp; req_crm = crm; cur_el = el;
        {el2_enabled, el2_is_32, el3_present, el3_is_32,
         hyp64_tde, hyp64_tda, hyp32_tde, hyp32_tda, mon64_tda} = cfg;
        e.oc  = oc;
        e.syn = (oc[2] | oc[3] | oc[4]) ? 6'h05 : 6'h00;
        e.wr  = ewr;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: a quarter period after each rising edge, compare with the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                logic [4:0] got;
                e = sb.pop_front();
                got = {res_trap_el3, res_hyp_trap, res_trap_el2, res_undef, res_permit};
                n_checks++;
                if (got !== e.oc || syn_class !== e.syn || reg_wr_en !== e.wr) begin
                    n_fail++;
                    $display("FAIL %s: outcome=%b syn=%h wr=%b expected outcome=%b syn=%h wr=%b",
                             e.tag, got, syn_class, reg_wr_en, e.oc, e.syn, e.wr);
                end
            end
        end
    end

    localparam logic [3:0] CP_OK = 4'b1110, CRM_OK = 4'b0010;

    initial begin
        // R10: permitted write at level 3 while in reset gives no strobe
        drive(1, 1, CP_OK, CRM_OK, 2'd3, 9'b0, E_PERM, 0, "R10 reset holds strobe low");
        drive(0, 0, CP_OK, CRM_OK, 2'd0, 9'b0, E_NONE, 0, "R10 reset idle");
        @(negedge clk); rst_n = 1'b1;
        drive(0, 0, CP_OK, CRM_OK, 2'd0, 9'b0, E_NONE, 0, "R8 idle after reset");
        drive(1, 1, CP_OK, CRM_OK, 2'd3, 9'b111111111, E_PERM, 1, "R6 level3 write all traps armed");
        drive(0, 0, CP_OK, CRM_OK, 2'd3, 9'b0, E_NONE, 0, "R9 strobe lasts one cycle");
        drive(1, 0, CP_OK, CRM_OK, 2'd0, 9'b0, E_UNDEF, 0, "R2 level0 read");
        drive(1, 1, CP_OK, CRM_OK, 2'd0, 9'b111111111, E_UNDEF, 0, "R2 level0 write armed");
        drive(1, 1, CP_OK, CRM_OK, 2'd1, 9'b100001000, E_EL2, 0, "R3 64-bit tda trap");
        drive(1, 0, CP_OK, CRM_OK, 2'd1, 9'b101010001, E_EL2, 0, "R3 tde beats monitor trap");
        drive(1, 1, CP_OK, CRM_OK, 2'd1, 9'b110000010, E_HYP, 0, "R4 32-bit tda hyp trap");
        drive(1, 0, CP_OK, CRM_OK, 2'd1, 9'b111000101, E_HYP, 0, "R4 hyp beats monitor trap");
        drive(1, 1, CP_OK, CRM_OK, 2'd1, 9'b111011001, E_EL3, 0, "R5 32-bit level2 ignores 64-bit bits");
        drive(1, 0, CP_OK, CRM_OK, 2'd1, 9'b001011111, E_EL3, 0, "R5 level2 disabled falls to monitor");
        drive(1, 1, CP_OK, CRM_OK, 2'd1, 9'b001100001, E_PERM, 1, "R5 32-bit level3 no trap, write");
        drive(1, 1, CP_OK, CRM_OK, 2'd2, 9'b100011110, E_PERM, 1, "R11 level2 ignores hyp bits");
        drive(1, 0, CP_OK, CRM_OK, 2'd2, 9'b101011111, E_EL3, 0, "R5 level2 monitor trap");
        drive(1, 0, CP_OK, CRM_OK, 2'd1, 9'b0, E_PERM, 0, "R9 permitted read no strobe");
        drive(1, 1, CP_OK, 4'b0011, 2'd3, 9'b0, E_NONE, 0, "R1 wrong CRm");
        drive(1, 1, 4'b1111, CRM_OK, 2'd0, 9'b111111111, E_NONE, 0, "R1 wrong coprocessor");
        drive(1, 1, CP_OK, CRM_OK, 2'd3, 9'b0, E_PERM, 1, "R9 back-to-back write 1");
        drive(1, 1, CP_OK, CRM_OK, 2'd2, 9'b0, E_PERM, 1, "R9 back-to-back write 2");
        drive(1, 1, CP_OK, CRM_OK, 2'd1, 9'b100001000, E_EL2, 0, "R7 trapped write no strobe");
        drive(0, 1, CP_OK, CRM_OK, 2'd3, 9'b0, E_NONE, 0, "R8 invalid request quiet");
        @(negedge clk);
        @(negedge clk);
        stim_done = 1;
    end

    // Watchdog and end of run.
    initial begin
        int cyc;
        cyc = 0;
        while (!stim_done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!stim_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: stimulus did not finish, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule